// File: doc/BRIEF.md
# PHY Management Master with Built-in PHY Register Model

This block is the management side of an Ethernet MAC. Software reaches PHY registers through it by way of a small set of registers. A configuration register holds an enable bit and a clock divider. A transfer command word names the target PHY, the target register and the operation, and carries a start bit. A write-data register supplies the value for write transfers. A read-data register receives the result of read transfers.

A transfer does not drive serial pins. Once accepted, it keeps the block busy for a fixed number of cycles and then completes against an internal 32-entry PHY register model. The model answers only at one PHY address, which is a parameter. Its status, partner-ability and diagnostic registers are not stored. They are computed from the link input and from the local advertisement register (register 4) at the moment they are read.

Top module: `phy_mgmt_master`

## Requirements
- R1: The command word (select 1) decodes the PHY address from bits 28:24, the register address from bits 20:16, the opcode from bits 15:14 and the start bit from bit 11. Opcode 1 writes and opcode 2 reads. Any other opcode with the start bit set moves no data, leaves `busy` low and sets `op_invalid`. Any other accepted command write clears `op_invalid`.
- R2: An accepted read or write holds `busy` high for exactly `BUSY_CYCLES` cycles. The transfer takes effect on the edge where `busy` falls.
- R3: A command-word write made while `busy` is high is ignored. The stored command word, the transfer in progress and `op_invalid` are all left unchanged.
- R4: Reading select 1 always returns the stored command word with bit 7 forced to 1. After reset this reads 0x00000080.
- R5: The configuration register (select 0) keeps only bits 6:0. `cfg_warn` is set by a configuration write that has bit 6 (enable) set and bits 5:0 (divider) equal to zero. Any other configuration write clears it.
- R6: A read aimed at a PHY address other than `PHY_ADDR` returns 0xFFFF. A write to such an address changes nothing.
- R7: After reset, PHY register 0 is 0x3100, register 2 is 0x0300, register 3 is 0xE400 and register 4 is 0x01E1.
- R8: PHY register 1 reads 0x782E when `link_up` is high and 0x0000 when it is low.
- R9: PHY register 5 reads 0x4001 OR'd with bits 8:5 of register 4.
- R10: PHY register 17 reads 0x8000. Register 18 reads 0 when the link is down. When the link is up, register 18 has bit 10 set if register 4 bit 7 or bit 8 is set, and bit 11 set if register 4 bit 8 or bit 6 is set. All other bits are 0.
- R11: A PHY write stores the 16-bit data latched from select 2 when the command was accepted. It then clears bits 15 and 9 of register 0.
- R12: A software write to the read-data register (select 3) normally stores the value. If it lands on the edge where a read completes, the read result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state seen by the PHY model |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 command, 2 write data, 3 read data |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 32 | Selected register contents |
| busy | output | 1 | Transfer in progress |
| op_invalid | output | 1 | Last accepted start used an unsupported opcode |
| cfg_warn | output | 1 | Enabled with a zero clock divider |

## Verification
The collision checked here is between two events on one edge: a read transfer completing and software writing the read-data register. A transfer is started, and the software write is then timed so that it is sampled on exactly the edge where `busy` falls. The PHY value must be what remains afterwards. A second collision is a new command written while a transfer is still busy. It is issued one cycle after a start, and the result of the first transfer, together with the command readback, shows whether the second command was ignored. A behavioural reference model runs beside the design and is compared against the outputs on every clock.

// File: rtl/phy_mgmt_pkg.sv
`timescale 1ns/1ps
package phy_mgmt_pkg;
    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_WDATA = 2'd2,
        SEL_RDATA = 2'd3
    } reg_sel_e;

    localparam int PADDR_LSB   = 24;
    localparam int RADDR_LSB   = 16;
    localparam int OP_LSB      = 14;
    localparam int GO_BIT      = 11;
    localparam int READY_BIT   = 7;
    localparam int CFG_EN_BIT  = 6;
    localparam int CFG_W       = 7;
    localparam int PHY_NREG    = 32;
    localparam int PHY_AW      = $clog2(PHY_NREG);

    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    typedef struct packed {
        logic              wr;
        logic [4:0]        phy;
        logic [PHY_AW-1:0] regn;
        logic [15:0]       data;
    } xfer_t;
endpackage

// File: rtl/phy_mgmt_seq.sv
`timescale 1ns/1ps
module phy_mgmt_seq
    import phy_mgmt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        busy,
    output logic        op_invalid,
    output logic        cfg_warn,
    output logic [31:0] ctrl_word,
    output logic        xfer_go,
    output xfer_t       xfer,
    input  logic [15:0] phy_rdata
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [31:0]      ctrl;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             invalid;
        logic             warn;
        xfer_t            pend;
    } seq_t;

    seq_t       s_d, s_q;
    logic       done;
    logic [1:0] op;

    always_comb begin
        s_d     = s_q;
        xfer_go = 1'b0;
        done    = s_q.busy && (s_q.cnt == '0);
        op      = wr_data[OP_LSB +: 2];

        if (s_q.busy) begin
            if (done) begin
                s_d.busy = 1'b0;
                xfer_go  = 1'b1;
                if (!s_q.pend.wr) begin
                    s_d.rdata = {16'h0000, phy_rdata};
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CFG: begin
                    s_d.cfg  = wr_data[CFG_W-1:0];
                    s_d.warn = wr_data[CFG_EN_BIT] && (wr_data[CFG_EN_BIT-1:0] == '0);
                end
                SEL_CTRL: begin
                    if (!s_q.busy) begin
                        s_d.ctrl    = wr_data;
                        s_d.invalid = 1'b0;
                        if (wr_data[GO_BIT]) begin
                            if (op == OP_WRITE || op == OP_READ) begin
                                s_d.busy      = 1'b1;
                                s_d.cnt       = CNT_W'(BUSY_CYCLES - 1);
                                s_d.pend.wr   = (op == OP_WRITE);
                                s_d.pend.phy  = wr_data[PADDR_LSB +: 5];
                                s_d.pend.regn = wr_data[RADDR_LSB +: PHY_AW];
                                s_d.pend.data = s_q.wdata[15:0];
                            end else begin
                                s_d.invalid = 1'b1;
                            end
                        end
                    end
                end
                SEL_WDATA: s_d.wdata = wr_data;
                default: begin
                    if (!(done && !s_q.pend.wr)) begin
                        s_d.rdata = wr_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CFG:   rd_data = {{(32-CFG_W){1'b0}}, s_q.cfg};
            SEL_CTRL:  rd_data = s_q.ctrl | (32'h1 << READY_BIT);
            SEL_WDATA: rd_data = s_q.wdata;
            default:   rd_data = s_q.rdata;
        endcase
    end

    assign busy       = s_q.busy;
    assign op_invalid = s_q.invalid;
    assign cfg_warn   = s_q.warn;
    assign ctrl_word  = s_q.ctrl;
    assign xfer       = s_q.pend;
endmodule

// File: rtl/phy_reg_bank.sv
`timescale 1ns/1ps
module phy_reg_bank
    import phy_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        go,
    input  xfer_t       xfer,
    output logic [15:0] rdata
);
    localparam logic [15:0] LINK_STATUS = 16'h782E;
    localparam logic [15:0] PARTNER_FIX = 16'h4001;
    localparam logic [15:0] ADV_MASK    = 16'h01E0;
    localparam logic [15:0] FAST_ID     = 16'h8000;
    localparam logic [15:0] R0_AUTOCLR  = 16'h8200;

    typedef logic [PHY_NREG-1:0][15:0] bank_t;

    bank_t       bank_d, bank_q;
    bank_t       bank_init;
    logic        hit;
    logic [15:0] adv;
    logic [15:0] look;

    // reset image: a handful of identity and capability words, the rest zero
    for (genvar i = 0; i < PHY_NREG; i++) begin : g_init
        if (i == 0)      begin : g_r0 assign bank_init[i] = 16'h3100; end
        else if (i == 2) begin : g_r2 assign bank_init[i] = 16'h0300; end
        else if (i == 3) begin : g_r3 assign bank_init[i] = 16'hE400; end
        else if (i == 4) begin : g_r4 assign bank_init[i] = 16'h01E1; end
        else             begin : g_rz assign bank_init[i] = 16'h0000; end
    end

    always_comb begin
        hit    = (xfer.phy == 5'(PHY_ADDR));
        bank_d = bank_q;
        if (go && xfer.wr && hit) begin
            bank_d[xfer.regn] = xfer.data;
            bank_d[0]         = bank_d[0] & ~R0_AUTOCLR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= bank_init;
        else        bank_q <= bank_d;
    end

    always_comb begin
        adv = bank_q[4];
        case (xfer.regn)
            PHY_AW'(1):  look = link_up ? LINK_STATUS : 16'h0000;
            PHY_AW'(5):  look = PARTNER_FIX | (adv & ADV_MASK);
            PHY_AW'(17): look = FAST_ID;
            PHY_AW'(18): look = link_up ? {4'b0000, adv[8] | adv[6], adv[8] | adv[7], 10'b0}
                                        : 16'h0000;
            default:     look = bank_q[xfer.regn];
        endcase
        rdata = hit ? look : 16'hFFFF;
    end
endmodule

// File: rtl/phy_mgmt_master.sv
`timescale 1ns/1ps
module phy_mgmt_master
    import phy_mgmt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int PHY_ADDR    = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        busy,
    output logic        op_invalid,
    output logic        cfg_warn
);
    logic [31:0] ctrl_word;
    logic        xfer_go;
    xfer_t       xfer;
    logic [15:0] phy_rdata;

    phy_mgmt_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .op_invalid(op_invalid),
        .cfg_warn(cfg_warn), .ctrl_word(ctrl_word), .xfer_go(xfer_go), .xfer(xfer),
        .phy_rdata(phy_rdata)
    );

    phy_reg_bank #(.PHY_ADDR(PHY_ADDR)) u_bank (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .go(xfer_go), .xfer(xfer),
        .rdata(phy_rdata)
    );
endmodule

// File: rtl/phy_mgmt_chk.sv
`timescale 1ns/1ps
module phy_mgmt_chk
    import phy_mgmt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int PHY_ADDR    = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        busy,
    input logic        op_invalid,
    input logic        cfg_warn,
    input logic [31:0] ctrl_word,
    input logic        xfer_go,
    input xfer_t       xfer,
    input logic [15:0] phy_rdata
);
    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == BUSY_CYCLES);

    // R2
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !busy);

    // R3
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en && wr_sel == 2'd1 |=> ctrl_word == $past(ctrl_word));

    // R1
    bad_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_invalid) |-> !busy);

    // R6
    absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go && !xfer.wr && xfer.phy != 5'(PHY_ADDR) |-> phy_rdata == 16'hFFFF);

    // R5
    cfg_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 |=>
            cfg_warn == ($past(wr_data[6]) && $past(wr_data[5:0]) == 6'd0));
endmodule

bind phy_mgmt_master phy_mgmt_chk #(.BUSY_CYCLES(BUSY_CYCLES), .PHY_ADDR(PHY_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .op_invalid(op_invalid), .cfg_warn(cfg_warn), .ctrl_word(ctrl_word),
    .xfer_go(xfer_go), .xfer(xfer), .phy_rdata(phy_rdata)
);

// File: tb/tb_phy_mgmt_master.sv
`timescale 1ns/1ps
module tb_phy_mgmt_master;
    localparam int N  = 4;
    localparam int PA = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        busy, op_invalid, cfg_warn;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_master #(.BUSY_CYCLES(N), .PHY_ADDR(PA)) dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy),
        .op_invalid(op_invalid), .cfg_warn(cfg_warn)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_phy [32];
    logic [31:0] m_cfg, m_ctrl, m_wd, m_rd;
    int          m_cnt;
    bit          m_inv, m_warn;
    bit          p_wr;
    int          p_phy, p_reg;
    logic [15:0] p_data;

    task automatic m_reset();
        foreach (m_phy[i]) m_phy[i] = 16'h0;
        m_phy[0] = 16'h3100; m_phy[2] = 16'h0300; m_phy[3] = 16'hE400; m_phy[4] = 16'h01E1;
        m_cfg = 0; m_ctrl = 0; m_wd = 0; m_rd = 0; m_cnt = 0; m_inv = 0; m_warn = 0;
        p_wr = 0; p_phy = 0; p_reg = 0; p_data = 0;
    endtask

    function automatic logic [15:0] m_phy_read(int pa, int ra);
        logic [15:0] a;
        a = m_phy[4];
        if (pa != PA) return 16'hFFFF;
        if (ra == 1)  return link_up ? 16'h782E : 16'h0;
        if (ra == 5)  return 16'h4001 | (a & 16'h01E0);
        if (ra == 17) return 16'h8000;
        if (ra == 18) begin
            if (!link_up) return 16'h0;
            return ((a[7] || a[8]) ? 16'h0400 : 16'h0) | ((a[6] || a[8]) ? 16'h0800 : 16'h0);
        end
        return m_phy[ra];
    endfunction

    always @(posedge clk) begin
        bit was_busy, fin;
        int op;
        if (!rst_n) begin
            m_reset();
        end else begin
            was_busy = (m_cnt > 0);
            fin = 0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                fin = (m_cnt == 0);
            end
            if (fin) begin
                if (p_wr) begin
                    if (p_phy == PA) begin
                        m_phy[p_reg] = p_data;
                        m_phy[0] = m_phy[0] & ~16'h8200;
                    end
                end else begin
                    m_rd = {16'h0, m_phy_read(p_phy, p_reg)};
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin
                        m_cfg = wr_data & 32'h7F;
                        m_warn = wr_data[6] && (wr_data[5:0] == 0);
                    end
                    2'd1: if (!was_busy) begin
                        m_ctrl = wr_data;
                        m_inv = 0;
                        if (wr_data[11]) begin
                            op = int'(wr_data[15:14]);
                            if (op == 1 || op == 2) begin
                                m_cnt = N; p_wr = (op == 1);
                                p_phy = int'(wr_data[28:24]); p_reg = int'(wr_data[20:16]);
                                p_data = m_wd[15:0];
                            end else begin
                                m_inv = 1;
                            end
                        end
                    end
                    2'd2: m_wd = wr_data;
                    default: if (!(fin && !p_wr)) m_rd = wr_data;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0:    return m_cfg;
            2'd1:    return m_ctrl | 32'h80;
            2'd2:    return m_wd;
            default: return m_rd;
        endcase
    endfunction

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            n_cmp += 4;
            if (busy !== (m_cnt > 0)) begin
                n_bad++; $display("FAIL R2 model busy act=%0b exp=%0b", busy, m_cnt > 0);
            end
            if (op_invalid !== m_inv) begin
                n_bad++; $display("FAIL R1 model op_invalid act=%0b exp=%0b", op_invalid, m_inv);
            end
            if (cfg_warn !== m_warn) begin
                n_bad++; $display("FAIL R5 model cfg_warn act=%0b exp=%0b", cfg_warn, m_warn);
            end
            if (rd_data !== exp_rd(rd_sel)) begin
                n_bad++; $display("FAIL R4 model rd_data sel=%0d act=%h exp=%h",
                                  rd_sel, rd_data, exp_rd(rd_sel));
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1 v = rd_data;
        @(negedge clk);
    endtask

    function automatic logic [31:0] cw(logic [4:0] pa, logic [4:0] ra, logic [1:0] op, logic go);
        return {3'b0, pa, 3'b0, ra, op, 2'b0, go, 11'b0};
    endfunction

    task automatic phy_rd(logic [4:0] pa, logic [4:0] ra, output logic [31:0] v);
        wr(2'd1, cw(pa, ra, 2'd2, 1'b1));
        repeat (N) @(negedge clk);
        peek(2'd3, v);
    endtask

    task automatic phy_wr(logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
        wr(2'd2, {16'h0, d});
        wr(2'd1, cw(pa, ra, 2'd1, 1'b1));
        repeat (N) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        peek(2'd1, v);  chk("R4 reset command readback", v, 32'h80);
        chk("R2 reset busy low", {31'b0, busy}, 32'h0);

        phy_rd(PA, 0, v);  chk("R7 reg0 reset", v, 32'h3100);
        phy_rd(PA, 2, v);  chk("R7 reg2 reset", v, 32'h0300);
        phy_rd(PA, 3, v);  chk("R7 reg3 reset", v, 32'hE400);
        phy_rd(PA, 4, v);  chk("R7 reg4 reset", v, 32'h01E1);
        phy_rd(PA, 1, v);  chk("R8 reg1 link up", v, 32'h782E);
        phy_rd(PA, 5, v);  chk("R9 reg5 default", v, 32'h41E1);
        phy_rd(PA, 17, v); chk("R10 reg17", v, 32'h8000);
        phy_rd(PA, 18, v); chk("R10 reg18 default", v, 32'h0C00);

        link_up = 1'b0;
        phy_rd(PA, 1, v);  chk("R8 reg1 link down", v, 32'h0);
        phy_rd(PA, 18, v); chk("R10 reg18 link down", v, 32'h0);
        link_up = 1'b1;

        // R2 busy duration
        wr(2'd1, cw(PA, 2, 2'd2, 1'b1));
        cnt = 0;
        while (busy && cnt < 20) begin cnt++; @(negedge clk); end
        chk("R2 busy cycles", cnt, N);
        peek(2'd3, v); chk("R2 read result after busy", v, 32'h0300);

        // R3 command while busy is ignored
        wr(2'd1, cw(PA, 3, 2'd2, 1'b1));
        wr(2'd1, cw(PA, 17, 2'd2, 1'b1));
        repeat (N) @(negedge clk);
        peek(2'd3, v); chk("R3 first read kept", v, 32'hE400);
        peek(2'd1, v); chk("R3 command readback kept", v, cw(PA, 3, 2'd2, 1'b1) | 32'h80);

        // R12 collision of read completion with software write
        wr(2'd1, cw(PA, 17, 2'd2, 1'b1));
        repeat (N - 1) @(negedge clk);
        wr(2'd3, 32'h1234);
        peek(2'd3, v); chk("R12 completion wins", v, 32'h8000);
        wr(2'd3, 32'h1234);
        peek(2'd3, v); chk("R12 idle software write", v, 32'h1234);

        // R1 opcode decode
        wr(2'd1, cw(PA, 1, 2'd0, 1'b1));
        chk("R1 opcode 0 invalid", {31'b0, op_invalid}, 32'h1);
        chk("R1 opcode 0 not busy", {31'b0, busy}, 32'h0);
        wr(2'd1, cw(PA, 1, 2'd3, 1'b1));
        chk("R1 opcode 3 invalid", {31'b0, op_invalid}, 32'h1);
        wr(2'd1, cw(PA, 1, 2'd2, 1'b0));
        chk("R1 no start clears invalid", {31'b0, op_invalid}, 32'h0);
        chk("R1 no start not busy", {31'b0, busy}, 32'h0);
        peek(2'd3, v); chk("R1 no transfer without start", v, 32'h1234);
        peek(2'd1, v); chk("R4 ready bit with plain word", v, cw(PA, 1, 2'd2, 1'b0) | 32'h80);

        // R6 absent PHY address
        phy_rd(5'd3, 2, v); chk("R6 absent read", v, 32'hFFFF);
        phy_wr(5'd3, 4, 16'h0000);
        phy_rd(PA, 4, v);   chk("R6 absent write no effect", v, 32'h01E1);

        // R9 / R10 with altered advertisement
        phy_wr(PA, 4, 16'h0040);
        phy_rd(PA, 5, v);  chk("R9 reg5 after adv 0040", v, 32'h4041);
        phy_rd(PA, 18, v); chk("R10 reg18 after adv 0040", v, 32'h0800);
        phy_wr(PA, 4, 16'h0080);
        phy_rd(PA, 5, v);  chk("R9 reg5 after adv 0080", v, 32'h4081);
        phy_rd(PA, 18, v); chk("R10 reg18 after adv 0080", v, 32'h0400);

        // R11 write auto-clear
        phy_wr(PA, 0, 16'hFFFF);
        phy_rd(PA, 0, v);  chk("R11 reg0 self clear", v, 32'h7DFF);
        phy_wr(PA, 9, 16'hABCD);
        phy_rd(PA, 9, v);  chk("R11 reg9 stored", v, 32'hABCD);

        // R5 configuration
        wr(2'd0, 32'hFFFF_FFFF);
        peek(2'd0, v); chk("R5 cfg low bits", v, 32'h7F);
        chk("R5 warn clear with divider", {31'b0, cfg_warn}, 32'h0);
        wr(2'd0, 32'h40);
        chk("R5 warn on zero divider", {31'b0, cfg_warn}, 32'h1);
        wr(2'd0, 32'h41);
        chk("R5 warn cleared", {31'b0, cfg_warn}, 32'h0);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule